// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel words into frames on a single asynchronous output line. A frame is a low start bit, then 5 to 9 data bits, then an optional parity bit, then a stop period at the high level. The stop period can be a half, one, one and a half or two bit periods long. The bit period is a whole number of clock cycles, set by a 16-bit divisor input. The data can be sent least significant bit first or most significant bit first.

Two polarity options are available. Line inversion flips every level on the wire, so the idle level becomes low. Data-only inversion flips the data and parity bits and leaves the start and stop bits at normal polarity.

Words enter through a valid/ready handshake. The block samples the whole frame format at the moment a word is accepted and keeps it for the rest of that frame. While a frame is on the line, `busy` is high and `in_ready` is low.

Top module: `async_frame_tx`

## Requirements
- R1: The line rests at level 1 while idle. In the cycle after a word is accepted, the line shows a start bit at level 0 that lasts exactly one bit period.
- R2: `cfg_len` selects the number of data bits. Codes 5 to 9 are used as given, codes below 5 act as 5 and codes above 9 act as 9. By default the bits go out from bit 0 upward. Bits of `in_word` at or above the selected length never reach the line.
- R3: With `cfg_msb_first`=1, the data bits go out from bit (length-1) down to bit 0.
- R4: `cfg_parity` selects the parity bit, which follows the last data bit. 0 = no parity bit. 1 = odd, so the count of ones in data plus parity is odd. 2 = even, so that count is even. 3 = a constant 1. 4 = a constant 0. Codes 5 to 7 act as 0.
- R5: `cfg_stop` selects the stop period at level 1. 0 = one bit period (D), 1 = D + floor(D/2), 2 = 2·D, 3 = floor(D/2).
- R6: Each start, data and parity bit lasts D clock cycles. D is `cfg_div`, except that values 0 and 1 are used as 2.
- R7: With `cfg_inv_line`=1, every level on the line is complemented. While idle, the line shows the complement of the `cfg_inv_line` value sampled at the previous clock edge.
- R8: With `cfg_inv_data`=1, the data and parity bits are complemented and the start and stop bits are not.
- R9: A word is accepted only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low and `busy` is high from the cycle after acceptance until the last stop cycle, inclusive. `in_valid` and `in_word` have no effect while busy.
- R10: Changes to `cfg_*`, `cfg_div` or `in_word` after acceptance do not change the frame already in progress.
- R11: While reset is asserted, `tx_out`=1, `in_ready`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block can accept a word |
| in_word | input | 9 | Word to send; the low bits are used |
| cfg_div | input | 16 | Bit period in clock cycles |
| cfg_len | input | 4 | Data length code |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop period code |
| cfg_msb_first | input | 1 | Send the most significant data bit first |
| cfg_inv_line | input | 1 | Complement all line levels |
| cfg_inv_data | input | 1 | Complement data and parity bits only |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | A frame is on the line |

## Verification
The bench goes after several corner cases, and each would show up in a specific way:

- **Half-period stop with an odd divisor.** A design that rounded up, or that counted one cycle too many or too few, would hold the stop level one cycle off.
- **Out-of-range codes.** Length codes outside 5 to 9, parity codes 5 to 7 and divisors of 0 or 1 are all driven. A design that decoded them literally would send the wrong number of bits, or a stray parity bit, or a bit period of one cycle or less.
- **Junk while busy.** The bench holds `in_valid` high with a different word and a scrambled configuration during a frame. A design that did not latch the format, or that kept listening while busy, would corrupt the frame or start an extra one.
- **Combined inversions.** The bench sets both inversion options together. A design that applied data-only inversion to the start and stop bits, or that got the idle level wrong under line inversion, would differ in those exact cycles.

// File: rtl/async_frame_tx.sv
module async_frame_tx #(
  parameter int DIV_W   = 16,
  parameter int MAX_LEN = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MAX_LEN-1:0] in_word,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [3:0]         cfg_len,
  input  logic [2:0]         cfg_parity,
  input  logic [1:0]         cfg_stop,
  input  logic               cfg_msb_first,
  input  logic               cfg_inv_line,
  input  logic               cfg_inv_data,
  output logic               tx_out,
  output logic               busy
);
  localparam int MIN_LEN = 5;
  localparam int CNT_W   = DIV_W + 1;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [3:0]         bit_idx;
  logic [MAX_LEN-1:0] shreg;
  logic [3:0]         len_q;
  logic [DIV_W-1:0]   dv_q;
  logic [CNT_W-1:0]   stop_q;
  logic               par_q, has_par_q, inv_d_q, line_inv_q;

  logic [3:0]         len_c;
  logic [DIV_W-1:0]   dv_c;
  logic [CNT_W-1:0]   dvx_c, stop_c;
  logic [MAX_LEN-1:0] ord_c;
  logic               par_c, has_par_c, lvl;
  logic               last;

  always_comb begin
    if (cfg_len < 4'(MIN_LEN))       len_c = 4'(MIN_LEN);
    else if (cfg_len > 4'(MAX_LEN))  len_c = 4'(MAX_LEN);
    else                             len_c = cfg_len;
  end

  assign dv_c  = (cfg_div < DIV_W'(2)) ? DIV_W'(2) : cfg_div;
  assign dvx_c = {1'b0, dv_c};

  always_comb begin
    for (int i = 0; i < MAX_LEN; i++) begin
      ord_c[i] = 1'b0;
      if (i < int'(len_c)) begin
        for (int j = 0; j < MAX_LEN; j++)
          if (cfg_msb_first && (j == int'(len_c) - 1 - i)) ord_c[i] = in_word[j];
        if (!cfg_msb_first) ord_c[i] = in_word[i];
      end
    end
  end

  always_comb begin
    has_par_c = 1'b1;
    case (cfg_parity)
      3'd1:    par_c = ~(^ord_c);
      3'd2:    par_c = ^ord_c;
      3'd3:    par_c = 1'b1;
      3'd4:    par_c = 1'b0;
      default: begin par_c = 1'b0; has_par_c = 1'b0; end
    endcase
  end

  always_comb begin
    case (cfg_stop)
      2'd0:    stop_c = dvx_c;
      2'd1:    stop_c = dvx_c + (dvx_c >> 1);
      2'd2:    stop_c = dvx_c << 1;
      default: stop_c = dvx_c >> 1;
    endcase
  end

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      len_q      <= 4'(MIN_LEN);
      dv_q       <= DIV_W'(2);
      stop_q     <= '0;
      par_q      <= 1'b0;
      has_par_q  <= 1'b0;
      inv_d_q    <= 1'b0;
      line_inv_q <= 1'b0;
    end else begin
      if (phase == PH_IDLE) line_inv_q <= cfg_inv_line;
      if (phase != PH_IDLE && !last) cnt <= cnt - 1'b1;
      case (phase)
        PH_IDLE: if (in_valid) begin
          phase     <= PH_START;
          cnt       <= dvx_c - 1'b1;
          shreg     <= ord_c;
          len_q     <= len_c;
          dv_q      <= dv_c;
          stop_q    <= stop_c;
          par_q     <= par_c;
          has_par_q <= has_par_c;
          inv_d_q   <= cfg_inv_data;
        end
        PH_START: if (last) begin
          phase   <= PH_DATA;
          cnt     <= {1'b0, dv_q} - 1'b1;
          bit_idx <= '0;
        end
        PH_DATA: if (last) begin
          if (bit_idx == len_q - 1'b1) begin
            phase <= has_par_q ? PH_PAR : PH_STOP;
            cnt   <= has_par_q ? {1'b0, dv_q} - 1'b1 : stop_q - 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= shreg >> 1;
            cnt     <= {1'b0, dv_q} - 1'b1;
          end
        end
        PH_PAR: if (last) begin
          phase <= PH_STOP;
          cnt   <= stop_q - 1'b1;
        end
        PH_STOP: if (last) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_START: lvl = 1'b0;
      PH_DATA:  lvl = shreg[0] ^ inv_d_q;
      PH_PAR:   lvl = par_q ^ inv_d_q;
      default:  lvl = 1'b1;
    endcase
  end

  assign tx_out   = lvl ^ line_inv_q;
  assign in_ready = (phase == PH_IDLE);
  assign busy     = (phase != PH_IDLE);
endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             busy,
  input logic             tx_out,
  input logic             cfg_inv_line,
  input logic             line_inv_q,
  input logic [DIV_W-1:0] dv_q,
  input logic [DIV_W:0]   cnt
);
  // R1 R7
  start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_out == $past(cfg_inv_line));

  // R9
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(in_valid) && $past(in_ready)));

  // R5
  stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_out) == !$past(line_inv_q));

  // R10
  frame_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(line_inv_q) && $stable(dv_q)));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < {dv_q, 1'b0});
endmodule

bind async_frame_tx async_frame_tx_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .tx_out(tx_out), .cfg_inv_line(cfg_inv_line),
  .line_inv_q(line_inv_q), .dv_q(dv_q), .cnt(cnt));

// File: tb/async_frame_tx_tb.sv
module async_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_word = '0;
  logic [15:0] cfg_div = 16'd4;
  logic [3:0]  cfg_len = 4'd8;
  logic [2:0]  cfg_parity = 3'd0;
  logic [1:0]  cfg_stop = 2'd0;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_inv_line = 1'b0;
  logic        cfg_inv_data = 1'b0;
  logic        tx_out;
  logic        busy;

  always #10 clk = ~clk;

  async_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_inv_line(cfg_inv_line), .cfg_inv_data(cfg_inv_data),
    .tx_out(tx_out), .busy(busy));

  int n_cmp = 0;
  int n_bad = 0;
  bit live = 1'b0;
  bit done = 1'b0;
  string test_tag = "R1";

  bit fq[$];
  int fr[$];
  bit m_busy = 1'b0;
  bit m_inv = 1'b0;
  bit exp_tx = 1'b1;
  int cur_req = 1;
  bit was_idle;

  function automatic string req_name(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic void push_seg(bit lv, int n, int r);
    for (int k = 0; k < n; k++) begin fq.push_back(lv); fr.push_back(r); end
  endfunction

  // Reference frame built from R1..R8 using the values present at the accepting edge
  function automatic void build();
    int d, len, ones, s;
    bit b, p, il, idd;
    d   = (cfg_div < 2) ? 2 : int'(cfg_div);
    len = (cfg_len < 5) ? 5 : (cfg_len > 9) ? 9 : int'(cfg_len);
    il  = cfg_inv_line;
    idd = cfg_inv_data;
    push_seg(1'b0 ^ il, d, 1);
    ones = 0;
    for (int i = 0; i < len; i++) begin
      b = cfg_msb_first ? in_word[len-1-i] : in_word[i];
      ones += int'(b);
      push_seg(b ^ idd ^ il, d, cfg_msb_first ? 3 : 2);
    end
    if (cfg_parity >= 1 && cfg_parity <= 4) begin
      case (cfg_parity)
        3'd1: p = (ones % 2 == 0);
        3'd2: p = (ones % 2 == 1);
        3'd3: p = 1'b1;
        default: p = 1'b0;
      endcase
      push_seg(p ^ idd ^ il, d, 4);
    end
    case (cfg_stop)
      2'd0: s = d;
      2'd1: s = d + d / 2;
      2'd2: s = 2 * d;
      default: s = d / 2;
    endcase
    push_seg(1'b1 ^ il, s, 5);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      fq.delete(); fr.delete();
      m_busy = 1'b0; m_inv = 1'b0; exp_tx = 1'b1; cur_req = 11;
    end else begin
      was_idle = !m_busy;
      if (was_idle) m_inv = cfg_inv_line;
      if (was_idle && in_valid) build();
      if (fq.size() > 0) begin
        exp_tx = fq.pop_front(); cur_req = fr.pop_front(); m_busy = 1'b1;
      end else begin
        m_busy = 1'b0; exp_tx = !m_inv; cur_req = m_inv ? 7 : 1;
      end
    end
  end

  task automatic check_bit(string rq, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (test %s) %s: actual %b expected %b at %0t",
               rq, test_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      check_bit(req_name(cur_req), "tx_out", tx_out, exp_tx);
      // R9 handshake state compared every cycle
      check_bit("R9", "in_ready", in_ready, !m_busy);
      check_bit("R9", "busy", busy, m_busy);
    end
  end

  task automatic send(string tag, logic [8:0] w, logic [3:0] len, logic [2:0] par,
                      logic [1:0] stp, bit msb, bit il, bit idd, logic [15:0] dv,
                      bit junk);
    bit r;
    @(negedge clk);
    test_tag = tag;
    in_word = w; cfg_len = len; cfg_parity = par; cfg_stop = stp;
    cfg_msb_first = msb; cfg_inv_line = il; cfg_inv_data = idd; cfg_div = dv;
    in_valid = 1'b1;
    forever begin
      r = in_ready;
      @(posedge clk);
      if (r) break;
    end
    @(negedge clk);
    if (junk) begin
      // R10 R9: scramble everything while the frame runs
      in_word = ~w; cfg_len = 4'd9 - (len & 4'd3); cfg_parity = par + 3'd1;
      cfg_stop = stp + 2'd1; cfg_msb_first = !msb; cfg_inv_line = !il;
      cfg_inv_data = !idd; cfg_div = dv + 16'd3;
      repeat (3) @(negedge clk);
    end
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: actual run still going, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset values
    check_bit("R11", "tx_out in reset", tx_out, 1'b1);
    check_bit("R11", "in_ready in reset", in_ready, 1'b1);
    check_bit("R11", "busy in reset", busy, 1'b0);
    rst_n = 1'b1;
    live = 1'b1;
    repeat (3) @(negedge clk);

    send("R2",  9'h05A, 4'd8, 3'd0, 2'd0, 0, 0, 0, 16'd4, 0);
    send("R2",  9'h1F3, 4'd5, 3'd1, 2'd0, 0, 0, 0, 16'd3, 0);
    send("R3",  9'h1A5, 4'd9, 3'd2, 2'd2, 1, 0, 0, 16'd5, 0);
    send("R3",  9'h0C1, 4'd6, 3'd0, 2'd0, 1, 0, 0, 16'd2, 0);
    send("R4",  9'h033, 4'd7, 3'd3, 2'd1, 0, 0, 0, 16'd5, 0);
    send("R4",  9'h0FF, 4'd8, 3'd4, 2'd3, 0, 0, 0, 16'd7, 0);
    send("R4",  9'h0AA, 4'd8, 3'd6, 2'd0, 0, 0, 0, 16'd3, 0);
    send("R5",  9'h011, 4'd5, 3'd1, 2'd3, 0, 0, 0, 16'd5, 0);
    send("R5",  9'h011, 4'd5, 3'd2, 2'd1, 0, 0, 0, 16'd3, 0);
    send("R6",  9'h0E7, 4'd8, 3'd1, 2'd0, 0, 0, 0, 16'd0, 0);
    send("R6",  9'h019, 4'd6, 3'd0, 2'd3, 0, 0, 0, 16'd1, 0);
    send("R2",  9'h155, 4'd2, 3'd0, 2'd0, 0, 0, 0, 16'd3, 0);
    send("R2",  9'h1C7, 4'd15, 3'd1, 2'd0, 1, 0, 0, 16'd3, 0);
    send("R7",  9'h06C, 4'd7, 3'd1, 2'd0, 0, 1, 0, 16'd4, 0);
    repeat (4) @(negedge clk);
    send("R8",  9'h093, 4'd8, 3'd2, 2'd2, 0, 0, 1, 16'd3, 0);
    send("R8",  9'h1B2, 4'd9, 3'd1, 2'd1, 1, 1, 1, 16'd4, 0);
    cfg_inv_line = 1'b0;
    repeat (4) @(negedge clk);
    send("R10", 9'h03C, 4'd8, 3'd1, 2'd0, 0, 0, 0, 16'd4, 1);
    send("R9",  9'h155, 4'd9, 3'd2, 2'd3, 1, 1, 0, 16'd3, 1);
    send("R9",  9'h0F0, 4'd8, 3'd0, 2'd0, 0, 0, 0, 16'd2, 0);

    for (int t = 0; t < 60; t++) begin
      send("R2", 9'($urandom), 4'($urandom_range(3, 11)), 3'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           16'($urandom_range(0, 9)), 1'($urandom));
    end
    repeat (5) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule